// File: doc/BRIEF.md
# Cache-Line Counter-Mode Encrypt and Tag Engine

This engine protects one 512-bit cache line on its way to or from untrusted memory. Each line uses its own nonce, made from an initialization value, the line's address and a 56-bit per-line write counter. It splits the line into four 128-bit blocks and XORs each block with a keystream pad. It also runs a Galois-field hash over the ciphertext blocks and masks the result to give a 64-bit tag that is stored as metadata. Decryption uses the same datapath. The hash is then taken over the incoming ciphertext, and the truncated tag is compared with the tag read back from memory.

The block cipher is outside the engine. For every pad it needs, the engine presents a 128-bit counter block and waits on a valid/ready pad port. The cipher therefore serves both the tag mask and the data pads, in a fixed order. Each request is accepted only while the engine is idle. The result, with its tag and mismatch flag, is held until the consumer takes it.

Top module: `line_gcm_engine`

## Requirements
- R1: After reset, req_ready is 1, and busy, pad_ready and res_valid are 0.
- R2: The counter block is, from MSB to LSB, {iv[31:0], addr[31:0], ctr[55:0], idx[7:0]}. For each line the engine requests pads with idx 0, 1, 2, 3, 4 in that order, one pad per handshake, and the nonce fields stay fixed while the line is in flight.
- R3: Data block k (k = 1..4) is line bits [128k-1 : 128(k-1)]. The matching result block is that input block XOR the pad received for idx k.
- R4: The hash starts at Y0 = 0, and Y_k = (Y_{k-1} XOR C_k) times H in GF(2^128). The reduction polynomial is x^128 + x^7 + x^2 + x + 1, and bit 127 of a word is the coefficient of x^0. C_k is the ciphertext block: the result block when encrypting, the input block when decrypting.
- R5: res_tag equals bits [127:64] of (Y4 XOR pad idx 0).
- R6: With req_decrypt = 1 the same pads are applied, so res_line returns the plaintext of a line encrypted with the same nonce.
- R7: With req_decrypt = 1, res_auth_fail is 1 exactly when the computed tag differs from req_tag.
- R8: With req_decrypt = 0, req_tag has no effect and res_auth_fail is 0.
- R9: From the cycle after acceptance until the result handshake, busy is 1 and req_ready is 0, so no second request is taken.
- R10: While res_valid is 1 and res_ready is 0, res_valid stays 1 and res_line, res_tag and res_auth_fail do not change.
- R11: At most one of req_ready, pad_ready and res_valid is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Line request offered |
| req_ready | output | 1 | Engine idle, request taken on valid |
| req_decrypt | input | 1 | 1 = decrypt and verify, 0 = encrypt |
| req_line | input | 512 | Plaintext or ciphertext line |
| req_addr | input | 32 | Line address for the nonce |
| req_ctr | input | 56 | Per-line counter for the nonce |
| req_iv | input | 32 | Initialization value for the nonce |
| req_hkey | input | 128 | Hash subkey H |
| req_tag | input | 64 | Stored tag to verify (decrypt only) |
| ctr_blk | output | 128 | Counter block for the external cipher |
| pad_ready | output | 1 | Engine waiting for a pad |
| pad_valid | input | 1 | Pad offered by the cipher |
| pad_data | input | 128 | Cipher output for ctr_blk |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_line | output | 512 | Transformed line |
| res_tag | output | 64 | Truncated authentication tag |
| res_auth_fail | output | 1 | Tag mismatch on decrypt |
| busy | output | 1 | Line in flight |

## Verification
The assertions rely on the external cipher keeping each pad tied to the counter block on display at the moment of the handshake. They also rely on the consumer following valid/ready rules. The bench's pad source computes every pad from the ctr_blk it observes, and it holds pad_valid only while pad_ready is high. It inserts gaps on the pad port and holds res_ready low for several cycles on every result. Requests are offered back to back while the engine is busy, to exercise the blocking behaviour.

// File: rtl/line_gcm_pkg.sv
package line_gcm_pkg;

    localparam int BLK_W  = 128;
    localparam int LINE_W = 512;
    localparam int NBLK   = LINE_W / BLK_W;
    localparam int SEL_W  = $clog2(NBLK);
    localparam int IV_W   = 32;
    localparam int ADDR_W = 32;
    localparam int CTR_W  = 56;
    localparam int IDX_W  = BLK_W - IV_W - ADDR_W - CTR_W;
    localparam int TAG_W  = 64;

    // reduction constant for the reflected field representation
    localparam logic [BLK_W-1:0] GF_RED = {8'hE1, {(BLK_W-8){1'b0}}};

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PAD,
        ST_MUL,
        ST_RES
    } eng_state_e;

    typedef struct packed {
        logic [IV_W-1:0]   iv;
        logic [ADDR_W-1:0] addr;
        logic [CTR_W-1:0]  ctr;
    } nonce_t;

    // multiply by x in the reflected representation
    function automatic logic [BLK_W-1:0] gf_times_x(input logic [BLK_W-1:0] v);
        return v[0] ? ((v >> 1) ^ GF_RED) : (v >> 1);
    endfunction

endpackage

// File: rtl/gcm_ctr_former.sv
module gcm_ctr_former
    import line_gcm_pkg::*;
(
    input  nonce_t             nonce,
    input  logic [IDX_W-1:0]   idx,
    output logic [BLK_W-1:0]   blk
);
    assign blk = {nonce, idx};
endmodule

// File: rtl/gcm_blk_xor.sv
module gcm_blk_xor
    import line_gcm_pkg::*;
(
    input  logic [LINE_W-1:0] line,
    input  logic [SEL_W-1:0]  sel,
    input  logic [BLK_W-1:0]  pad,
    output logic [BLK_W-1:0]  in_blk,
    output logic [BLK_W-1:0]  out_blk
);
    logic [BLK_W-1:0] blks [NBLK];

    generate
        for (genvar g = 0; g < NBLK; g++) begin : g_split
            assign blks[g] = line[g*BLK_W +: BLK_W];
        end
    endgenerate

    assign in_blk  = blks[sel];
    assign out_blk = in_blk ^ pad;
endmodule

// File: rtl/gcm_gf_mul_serial.sv
module gcm_gf_mul_serial
    import line_gcm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [BLK_W-1:0] a,
    input  logic [BLK_W-1:0] b,
    output logic             done,
    output logic [BLK_W-1:0] prod
);
    localparam int CNT_W = $clog2(BLK_W);

    logic [BLK_W-1:0] z_q, v_q, x_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q, done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            z_q    <= '0;
            v_q    <= '0;
            x_q    <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                z_q   <= '0;
                v_q   <= b;
                x_q   <= a;
                cnt_q <= '0;
                run_q <= 1'b1;
            end else if (run_q) begin
                if (x_q[BLK_W-1]) begin
                    z_q <= z_q ^ v_q;
                end
                v_q   <= gf_times_x(v_q);
                x_q   <= x_q << 1;
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CNT_W'(BLK_W - 1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done = done_q;
    assign prod = z_q;
endmodule

// File: rtl/line_gcm_engine.sv
module line_gcm_engine
    import line_gcm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_decrypt,
    input  logic [LINE_W-1:0] req_line,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CTR_W-1:0]  req_ctr,
    input  logic [IV_W-1:0]   req_iv,
    input  logic [BLK_W-1:0]  req_hkey,
    input  logic [TAG_W-1:0]  req_tag,
    output logic [BLK_W-1:0]  ctr_blk,
    output logic              pad_ready,
    input  logic              pad_valid,
    input  logic [BLK_W-1:0]  pad_data,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [LINE_W-1:0] res_line,
    output logic [TAG_W-1:0]  res_tag,
    output logic              res_auth_fail,
    output logic              busy
);
    eng_state_e        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic              dec_q;
    nonce_t            nonce_q;
    logic [BLK_W-1:0]  hkey_q;
    logic [TAG_W-1:0]  stag_q;
    logic [LINE_W-1:0] in_q;
    logic [LINE_W-1:0] out_q;
    logic [TAG_W-1:0]  mask_q;
    logic [BLK_W-1:0]  ghash_q;

    logic [SEL_W-1:0]  sel;
    logic [BLK_W-1:0]  in_blk, out_blk, cipher_blk;
    logic              pad_fire, data_fire, mul_done;
    logic [BLK_W-1:0]  mul_prod;

    gcm_ctr_former u_ctr (
        .nonce (nonce_q),
        .idx   (idx_q),
        .blk   (ctr_blk)
    );

    assign sel = SEL_W'(idx_q - IDX_W'(1));

    gcm_blk_xor u_xor (
        .line    (in_q),
        .sel     (sel),
        .pad     (pad_data),
        .in_blk  (in_blk),
        .out_blk (out_blk)
    );

    assign pad_fire   = (state_q == ST_PAD) && pad_valid;
    assign data_fire  = pad_fire && (idx_q != '0);
    assign cipher_blk = dec_q ? in_blk : out_blk;

    gcm_gf_mul_serial u_mul (
        .clk   (clk),
        .rst   (rst),
        .start (data_fire),
        .a     (ghash_q ^ cipher_blk),
        .b     (hkey_q),
        .done  (mul_done),
        .prod  (mul_prod)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            dec_q   <= 1'b0;
            nonce_q <= '0;
            hkey_q  <= '0;
            stag_q  <= '0;
            in_q    <= '0;
            out_q   <= '0;
            mask_q  <= '0;
            ghash_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        dec_q        <= req_decrypt;
                        nonce_q.iv   <= req_iv;
                        nonce_q.addr <= req_addr;
                        nonce_q.ctr  <= req_ctr;
                        hkey_q       <= req_hkey;
                        stag_q       <= req_tag;
                        in_q         <= req_line;
                        out_q        <= '0;
                        ghash_q      <= '0;
                        idx_q        <= '0;
                        state_q      <= ST_PAD;
                    end
                end
                ST_PAD: begin
                    if (pad_valid) begin
                        if (idx_q == '0) begin
                            mask_q <= pad_data[BLK_W-1 -: TAG_W];
                            idx_q  <= IDX_W'(1);
                        end else begin
                            out_q[sel*BLK_W +: BLK_W] <= out_blk;
                            state_q <= ST_MUL;
                        end
                    end
                end
                ST_MUL: begin
                    if (mul_done) begin
                        ghash_q <= mul_prod;
                        if (idx_q == IDX_W'(NBLK)) begin
                            state_q <= ST_RES;
                        end else begin
                            idx_q   <= idx_q + 1'b1;
                            state_q <= ST_PAD;
                        end
                    end
                end
                ST_RES: begin
                    if (res_ready) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy          = (state_q != ST_IDLE);
    assign req_ready     = (state_q == ST_IDLE);
    assign pad_ready     = (state_q == ST_PAD);
    assign res_valid     = (state_q == ST_RES);
    assign res_line      = out_q;
    assign res_tag       = ghash_q[BLK_W-1 -: TAG_W] ^ mask_q;
    assign res_auth_fail = dec_q && (res_tag != stag_q);
endmodule

// File: rtl/line_gcm_checker.sv
module line_gcm_checker
    import line_gcm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              busy,
    input logic              pad_ready,
    input logic              pad_valid,
    input logic              res_valid,
    input logic              res_ready,
    input logic [BLK_W-1:0]  ctr_blk,
    input logic [LINE_W-1:0] res_line,
    input logic [TAG_W-1:0]  res_tag,
    input logic              res_auth_fail
);
    AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (busy && !req_ready)); // R9

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_line)
            && $stable(res_tag) && $stable(res_auth_fail))); // R10

    AST_PHASE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({req_ready, pad_ready, res_valid})); // R11

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        pad_ready |-> (ctr_blk[IDX_W-1:0] <= IDX_W'(NBLK))); // R2

    AST_MASK_THEN_FIRST: assert property (@(posedge clk) disable iff (rst)
        (pad_ready && pad_valid && (ctr_blk[IDX_W-1:0] == '0))
            |=> (pad_ready && (ctr_blk[IDX_W-1:0] == IDX_W'(1)))); // R2

    AST_NONCE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (busy && !(res_valid && res_ready)) |=> $stable(ctr_blk[BLK_W-1:IDX_W])); // R2
endmodule

bind line_gcm_engine line_gcm_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .busy          (busy),
    .pad_ready     (pad_ready),
    .pad_valid     (pad_valid),
    .res_valid     (res_valid),
    .res_ready     (res_ready),
    .ctr_blk       (ctr_blk),
    .res_line      (res_line),
    .res_tag       (res_tag),
    .res_auth_fail (res_auth_fail)
);

// File: tb/sim_line_gcm_engine.sv
module sim_line_gcm_engine;
    import line_gcm_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_decrypt = 1'b0;
    logic [LINE_W-1:0] req_line = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [CTR_W-1:0]  req_ctr = '0;
    logic [IV_W-1:0]   req_iv = '0;
    logic [BLK_W-1:0]  req_hkey = '0;
    logic [TAG_W-1:0]  req_tag = '0;
    logic [BLK_W-1:0]  ctr_blk;
    logic              pad_ready;
    logic              pad_valid = 1'b0;
    logic [BLK_W-1:0]  pad_data = '0;
    logic              res_valid;
    logic              res_ready = 1'b0;
    logic [LINE_W-1:0] res_line;
    logic [TAG_W-1:0]  res_tag;
    logic              res_auth_fail;
    logic              busy;

    always #(CLK_PERIOD/2) clk = ~clk;

    line_gcm_engine u0 (.*);

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic [LINE_W-1:0] line;
        logic [TAG_W-1:0]  tag;
        logic              fail;
        string             name;
    } exp_t;

    exp_t              exp_q[$];
    logic [BLK_W-1:0]  cb_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // stand-in for the block cipher: a keyed scramble of the counter block
    function automatic logic [BLK_W-1:0] cipher_model(input logic [BLK_W-1:0] cb);
        logic [BLK_W-1:0] f;
        f = (cb ^ 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0) * 128'h9e3779b97f4a7c15f39cc0605cedc835;
        f = {f[63:0], f[127:64]} ^ 128'h5a5a0000ffff1234c3c3a5a5deadbeef;
        return f;
    endfunction

    // field product by the textbook shift-and-add definition
    function automatic logic [BLK_W-1:0] gmul(input logic [BLK_W-1:0] x, input logic [BLK_W-1:0] y);
        logic [BLK_W-1:0] z, v;
        z = '0;
        v = y;
        for (int i = 0; i < BLK_W; i++) begin
            if (x[BLK_W-1-i]) z = z ^ v;
            if (v[0]) v = (v >> 1) ^ {8'hE1, 120'd0};
            else      v = v >> 1;
        end
        return z;
    endfunction

    task automatic send(input logic dec, input logic [LINE_W-1:0] line,
                        input logic [ADDR_W-1:0] addr, input logic [CTR_W-1:0] ctr,
                        input logic [IV_W-1:0] iv, input logic [BLK_W-1:0] h,
                        input logic [TAG_W-1:0] stag, input string name,
                        output logic [LINE_W-1:0] out_line, output logic [TAG_W-1:0] out_tag);
        exp_t             e;
        logic [BLK_W-1:0] cb, p0, pk, inb, outb, y;
        logic [BLK_W-1:0] full;
        cb = {iv, addr, ctr, 8'd0};
        cb_q.push_back(cb);
        p0 = cipher_model(cb);
        y = '0;
        out_line = '0;
        for (int k = 1; k <= NBLK; k++) begin
            cb = {iv, addr, ctr, 8'(k)};
            cb_q.push_back(cb);
            pk   = cipher_model(cb);
            inb  = line[(k-1)*BLK_W +: BLK_W];
            outb = inb ^ pk;
            out_line[(k-1)*BLK_W +: BLK_W] = outb;
            y = gmul(y ^ (dec ? inb : outb), h);
        end
        full    = y ^ p0;
        out_tag = full[127:64];
        e.line = out_line;
        e.tag  = out_tag;
        e.fail = dec && (out_tag != stag);
        e.name = name;
        exp_q.push_back(e);

        @(negedge clk);
        req_decrypt = dec;
        req_line    = line;
        req_addr    = addr;
        req_ctr     = ctr;
        req_iv      = iv;
        req_hkey    = h;
        req_tag     = stag;
        req_valid   = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy && !req_ready, "R9", "busy after accept",
            LINE_W'({busy, req_ready}), LINE_W'(2'b10));
    endtask

    // pad source with gaps; checks every counter block it serves
    int stall = 0;
    always @(negedge clk) begin
        stall = (stall + 1) % 3;
        if (!rst && pad_ready && stall != 0) begin
            logic [BLK_W-1:0] e;
            pad_valid = 1'b1;
            pad_data  = cipher_model(ctr_blk);
            if (cb_q.size() == 0) begin
                chk(1'b0, "R2", "unexpected pad request", LINE_W'(ctr_blk), '0);
            end else begin
                e = cb_q.pop_front();
                chk(ctr_blk == e, "R2", "counter block", LINE_W'(ctr_blk), LINE_W'(e));
            end
        end else begin
            pad_valid = 1'b0;
        end
    end

    // result monitor with backpressure
    int hold = 0;
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            hold++;
            res_ready = (hold >= 4);
            if (res_ready) begin
                exp_t e;
                hold = 0;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected result", res_line, '0);
                end else begin
                    e = exp_q.pop_front();
                    chk(res_line == e.line, "R3 R6", {e.name, " line"}, res_line, e.line);
                    chk(res_tag == e.tag, "R4 R5", {e.name, " tag"},
                        LINE_W'(res_tag), LINE_W'(e.tag));
                    chk(res_auth_fail == e.fail, "R7 R8", {e.name, " auth_fail"},
                        LINE_W'(res_auth_fail), LINE_W'(e.fail));
                end
            end
        end else begin
            res_ready = 1'b0;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        chk(1'b0, "R9", "watchdog expired", '0, '0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [LINE_W-1:0] line_a, ct_a, scratch;
        logic [TAG_W-1:0]  tag_a, tscratch;
        logic [BLK_W-1:0]  h1;
        h1 = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;
        line_a = {128'hfeedfacedeadbeef0011223344556677, 128'h8899aabbccddeeff0123456789abcdef,
                  128'hd9313225f88406e5a55909c5aff5269a, 128'h86a7a9531534f7da2e4c303d8a318a72};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "req_ready", LINE_W'(req_ready), LINE_W'(1));
        chk(busy == 1'b0, "R1", "busy", LINE_W'(busy), '0);
        chk(pad_ready == 1'b0, "R1", "pad_ready", LINE_W'(pad_ready), '0);
        chk(res_valid == 1'b0, "R1", "res_valid", LINE_W'(res_valid), '0);

        // R8: encrypt with a junk stored tag
        send(1'b0, line_a, 32'h0000_1240, 56'h5, 32'hcafe_f00d, h1, 64'hffff_0000_1234_5678,
             "R8 encrypt", ct_a, tag_a);
        // R6 R7: decrypt the ciphertext with the right tag (offered while busy: R9)
        send(1'b1, ct_a, 32'h0000_1240, 56'h5, 32'hcafe_f00d, h1, tag_a,
             "R6 decrypt good", scratch, tscratch);
        // R7: decrypt with a single flipped tag bit
        send(1'b1, ct_a, 32'h0000_1240, 56'h5, 32'hcafe_f00d, h1, tag_a ^ 64'h1,
             "R7 decrypt bad tag", scratch, tscratch);
        // R7: decrypt at a relocated address
        send(1'b1, ct_a, 32'h0000_2280, 56'h5, 32'hcafe_f00d, h1, tag_a,
             "R7 decrypt moved", scratch, tscratch);
        // R4: field identity as H
        send(1'b0, line_a, 32'h0000_2280, 56'hab_cdef_0123_4567, 32'h0, {1'b1, 127'd0}, 64'h0,
             "R4 identity H", scratch, tscratch);
        // R5: zero H leaves only the mask
        send(1'b0, '0, 32'hffff_ffc0, 56'hff_ffff_ffff_ffff, 32'hffff_ffff, '0, 64'h0,
             "R5 zero H", scratch, tscratch);

        while (exp_q.size() != 0 || busy) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(cb_q.size() == 0, "R2", "all pads served", LINE_W'(cb_q.size()), '0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule